// File: doc/BRIEF.md
# Segment Remapping Cache with Restricted Placement

This block sits in the request path of a two-tier memory system in which a small fast tier and a four-times-larger slow tier share one flat physical address space. The address the operating system sees is cut into 2 KB segments. Each segment number splits into a slot index (low bits) and a group number (high bits). Group 0 is the fast tier. Groups 1 to 4 are the slow tier. All segments with the same slot index compete for the single fast slot of that index. A table in fast memory keeps one entry per slot, and that entry names the group whose segment now sits in the slot.

The block keeps recently used table entries in a small 4-way set-associative cache and uses them to turn each incoming address into the DRAM address where the data actually lives. A segment can only ever be placed in its own slot. So a cache miss needs only one table read, at the slot index, before the request can be answered.

When data movement elsewhere swaps a segment into a slot, the new resident group is given to the update port. The block passes it straight to the table write port and also patches the cached copy, if there is one. This keeps the cache and the table in agreement. An update that lands on the slot of a miss still in flight also replaces the value that the read returns.

Top module: `srm_remap_cache`

## Requirements
- R1: After synchronous reset: `req_ready` is 1, `resp_valid` is 0, `tbl_rd_req` is 0, and the cache holds no entries, so the first access to any slot takes a table read.
- R2: An address is `{group[2:0], slot[SLOT_W-1:0], offset[10:0]}`. The slot is the segment number modulo the fast slot count (2^SLOT_W). The 11-bit offset always passes to the output unchanged.
- R3: If the requested group equals the resident group of its slot, the result is the fast address `{3'd0, slot, offset}`.
- R4: If the requested group is 0 and a different group is resident, the result is that resident's slow home `{resident, slot, offset}`.
- R5: In every other case, including group codes 5 to 7, the address is returned unchanged.
- R6: A request that hits in the cache gets `resp_valid` one cycle after it is accepted, with no table read.
- R7: On a miss, `req_ready` stays low and `tbl_rd_req` is held with a stable `tbl_rd_slot` until `tbl_rd_rvalid`. Exactly one table read is made. The response follows one cycle after the data returns, and the entry is installed.
- R8: The cache has 2^SET_W sets (set = low SET_W bits of the slot) and 4 ways. A fill goes to the lowest-numbered invalid way, or else to the least recently used way. Both hits and fills count as a use.
- R9: An update is presented on the table write port in the same cycle, and it rewrites the cached copy of that slot if one is present, so later hits use the new resident.
- R10: An update to the slot of an outstanding miss replaces the data returned by that table read.
- R11: Requests with different group numbers but the same slot share one cache entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | OS-visible physical address |
| resp_valid | output | 1 | Translated address valid (one-cycle pulse) |
| resp_addr | output | ADDR_W | DRAM address |
| tbl_rd_req | output | 1 | Table read request, held until data returns |
| tbl_rd_slot | output | SLOT_W | Table entry index to read |
| tbl_rd_rvalid | input | 1 | Table read data valid |
| tbl_rd_data | input | 3 | Resident group read from the table |
| upd_valid | input | 1 | Swap update present |
| upd_slot | input | SLOT_W | Slot whose resident changed |
| upd_grp | input | 3 | New resident group |
| tbl_wr_valid | output | 1 | Table write strobe |
| tbl_wr_slot | output | SLOT_W | Table entry index to write |
| tbl_wr_grp | output | 3 | Resident group to write |

## Verification
A wrong internal state shows up in one of two ways. A bad tag or a bad valid bit turns a hit into a miss, or the reverse. That shows on the very next access to the slot: the response latency changes and a table read appears or goes missing. A wrong resident group, a lost update or a stale fill shows in the returned address of the first request to that slot afterwards. A broken replacement order may stay hidden until a set has been filled past four entries. Because of that, the bench walks one set through several evictions and checks which later accesses need a table read.

// File: rtl/srm_pkg.sv
package srm_pkg;

    // Remapping granularity and tier ratio
    localparam int SEG_BYTES  = 2048;
    localparam int OFF_W      = $clog2(SEG_BYTES);
    localparam int SLOW_RATIO = 4;
    localparam int GRP_W      = $clog2(SLOW_RATIO + 1);

    typedef logic [GRP_W-1:0] grp_t;
    typedef logic [OFF_W-1:0] off_t;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } fsm_t;

    // Group 0 is the fast tier home of every slot
    function automatic logic grp_is_fast(grp_t g);
        return g == '0;
    endfunction

endpackage

// File: rtl/srm_xlate.sv
module srm_xlate
    import srm_pkg::*;
#(
    parameter  int SLOT_W = 8,
    localparam int ADDR_W = GRP_W + SLOT_W + OFF_W
) (
    input  grp_t              in_grp,
    input  logic [SLOT_W-1:0] in_slot,
    input  off_t              in_off,
    input  grp_t              res_grp,
    output logic [ADDR_W-1:0] out_addr
);

    always_comb begin
        if (in_grp == res_grp) begin
            // requested segment occupies the fast slot
            out_addr = {{GRP_W{1'b0}}, in_slot, in_off};
        end else if (grp_is_fast(in_grp)) begin
            // slot owner displaced: it lives at the resident's slow home
            out_addr = {res_grp, in_slot, in_off};
        end else begin
            out_addr = {in_grp, in_slot, in_off};
        end
    end

endmodule

// File: rtl/srm_tag_array.sv
module srm_tag_array
    import srm_pkg::*;
#(
    parameter  int NSET  = 16,
    parameter  int WAYS  = 4,
    parameter  int TAG_W = 4,
    localparam int SET_W = $clog2(NSET),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    // request lookup
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way,
    output grp_t             lk_grp,
    // update lookup
    input  logic [SET_W-1:0] up_set,
    input  logic [TAG_W-1:0] up_tag,
    output logic             up_hit,
    output logic [WAY_W-1:0] up_way,
    // valid bits of one set for victim choice
    input  logic [SET_W-1:0] vq_set,
    output logic [WAYS-1:0]  vq_valid,
    // fill write
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  grp_t             fill_grp,
    // in-place modify of resident group
    input  logic             mod_en,
    input  logic [SET_W-1:0] mod_set,
    input  logic [WAY_W-1:0] mod_way,
    input  grp_t             mod_grp
);

    logic             vld_q [WAYS][NSET];
    logic [TAG_W-1:0] tag_q [WAYS][NSET];
    grp_t             grp_q [WAYS][NSET];

    logic [WAYS-1:0]  lk_match;
    logic [WAYS-1:0]  up_match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign lk_match[w] = vld_q[w][lk_set] && (tag_q[w][lk_set] == lk_tag);
        assign up_match[w] = vld_q[w][up_set] && (tag_q[w][up_set] == up_tag);
        assign vq_valid[w] = vld_q[w][vq_set];
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_way = '0;
        up_hit = 1'b0;
        up_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_match[w] && !lk_hit) begin
                lk_hit = 1'b1;
                lk_way = WAY_W'(w);
            end
            if (up_match[w] && !up_hit) begin
                up_hit = 1'b1;
                up_way = WAY_W'(w);
            end
        end
        lk_grp = grp_q[lk_way][lk_set];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int s = 0; s < NSET; s++) begin
                    vld_q[w][s] <= 1'b0;
                end
            end
        end else begin
            if (mod_en) begin
                grp_q[mod_way][mod_set] <= mod_grp;
            end
            if (fill_en) begin
                vld_q[fill_way][fill_set] <= 1'b1;
                tag_q[fill_way][fill_set] <= fill_tag;
                grp_q[fill_way][fill_set] <= fill_grp;
            end
        end
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));                                           // R8

    AST_UP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(up_match));                                           // R9

    AST_MOD_ON_VALID: assert property (@(posedge clk) disable iff (rst)
        mod_en |-> vld_q[mod_way][mod_set]);                           // R9

endmodule

// File: rtl/srm_lru.sv
module srm_lru #(
    parameter  int NSET  = 16,
    parameter  int WAYS  = 4,
    localparam int SET_W = $clog2(NSET),
    localparam int WAY_W = $clog2(WAYS),
    localparam int AGE_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] q_set,
    input  logic [WAYS-1:0]  q_valid,
    output logic [WAY_W-1:0] victim
);

    // age 0 = most recent, WAYS-1 = least recent; each set holds a permutation
    logic [AGE_W-1:0] age_q [NSET][WAYS];

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!q_valid[w] && !found) begin
                found  = 1'b1;
                victim = WAY_W'(w);
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[q_set][w] == AGE_W'(WAYS - 1)) begin
                    victim = WAY_W'(w);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSET; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (w == int'(touch_way)) begin
                    age_q[touch_set][w] <= '0;
                end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                end
            end
        end
    end

    for (genvar gs = 0; gs < NSET; gs++) begin : g_chk
        logic [WAYS-1:0] seen;
        always_comb begin
            seen = '0;
            for (int w = 0; w < WAYS; w++) begin
                seen[age_q[gs][w]] = 1'b1;
            end
        end
        AST_AGES_DISTINCT: assert property (@(posedge clk) disable iff (rst)
            &seen);                                                    // R8
    end

endmodule

// File: rtl/srm_remap_cache.sv
module srm_remap_cache
    import srm_pkg::*;
#(
    parameter  int SLOT_W = 8,
    parameter  int SET_W  = 4,
    parameter  int WAYS   = 4,
    localparam int ADDR_W = GRP_W + SLOT_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] resp_addr,
    output logic              tbl_rd_req,
    output logic [SLOT_W-1:0] tbl_rd_slot,
    input  logic              tbl_rd_rvalid,
    input  logic [GRP_W-1:0]  tbl_rd_data,
    input  logic              upd_valid,
    input  logic [SLOT_W-1:0] upd_slot,
    input  logic [GRP_W-1:0]  upd_grp,
    output logic              tbl_wr_valid,
    output logic [SLOT_W-1:0] tbl_wr_slot,
    output logic [GRP_W-1:0]  tbl_wr_grp
);

    localparam int NSET  = 1 << SET_W;
    localparam int TAG_W = SLOT_W - SET_W;
    localparam int WAY_W = $clog2(WAYS);

    // ---------------- state ----------------
    fsm_t              state_q;
    grp_t              pend_grp_q;
    logic [SLOT_W-1:0] pend_slot_q;
    off_t              pend_off_q;
    logic              ovr_v_q;
    grp_t              ovr_grp_q;
    logic              resp_valid_q;
    logic [ADDR_W-1:0] resp_addr_q;

    // ---------------- request decode ----------------
    grp_t              req_grp;
    logic [SLOT_W-1:0] req_slot;
    off_t              req_off;
    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;
    logic              req_fire;

    assign {req_grp, req_slot, req_off} = req_addr;
    assign req_set   = req_slot[SET_W-1:0];
    assign req_tag   = req_slot[SLOT_W-1:SET_W];
    assign req_ready = (state_q == ST_IDLE);
    assign req_fire  = req_valid && req_ready;

    // ---------------- cache lookup ----------------
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    grp_t              lk_grp;
    logic              up_hit;
    logic [WAY_W-1:0]  up_way;
    logic [WAYS-1:0]   vq_valid;
    logic [WAY_W-1:0]  victim;

    logic [SET_W-1:0]  pend_set;
    logic [TAG_W-1:0]  pend_tag;
    logic [SET_W-1:0]  upd_set;
    logic [TAG_W-1:0]  upd_tag;

    assign pend_set = pend_slot_q[SET_W-1:0];
    assign pend_tag = pend_slot_q[SLOT_W-1:SET_W];
    assign upd_set  = upd_slot[SET_W-1:0];
    assign upd_tag  = upd_slot[SLOT_W-1:SET_W];

    // ---------------- fill and update control ----------------
    logic fill_en;
    logic upd_hits_pend;
    grp_t fill_grp;
    logic mod_en;
    logic touch_en;
    logic [SET_W-1:0] touch_set;
    logic [WAY_W-1:0] touch_way;

    assign fill_en       = (state_q == ST_WAIT) && tbl_rd_rvalid;
    assign upd_hits_pend = (state_q == ST_WAIT) && upd_valid && (upd_slot == pend_slot_q);

    always_comb begin
        if (upd_hits_pend) begin
            fill_grp = upd_grp;
        end else if (ovr_v_q) begin
            fill_grp = ovr_grp_q;
        end else begin
            fill_grp = tbl_rd_data;
        end
    end

    // an update whose way is being evicted by this fill must not touch the new line
    assign mod_en = upd_valid && up_hit &&
                    !(fill_en && (pend_set == upd_set) && (victim == up_way));

    assign touch_en  = (req_fire && lk_hit) || fill_en;
    assign touch_set = fill_en ? pend_set : req_set;
    assign touch_way = fill_en ? victim   : lk_way;

    srm_tag_array #(
        .NSET  (NSET),
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .lk_set   (req_set),
        .lk_tag   (req_tag),
        .lk_hit   (lk_hit),
        .lk_way   (lk_way),
        .lk_grp   (lk_grp),
        .up_set   (upd_set),
        .up_tag   (upd_tag),
        .up_hit   (up_hit),
        .up_way   (up_way),
        .vq_set   (pend_set),
        .vq_valid (vq_valid),
        .fill_en  (fill_en),
        .fill_set (pend_set),
        .fill_way (victim),
        .fill_tag (pend_tag),
        .fill_grp (fill_grp),
        .mod_en   (mod_en),
        .mod_set  (upd_set),
        .mod_way  (up_way),
        .mod_grp  (upd_grp)
    );

    srm_lru #(
        .NSET (NSET),
        .WAYS (WAYS)
    ) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_set (touch_set),
        .touch_way (touch_way),
        .q_set     (pend_set),
        .q_valid   (vq_valid),
        .victim    (victim)
    );

    // ---------------- translation ----------------
    logic [ADDR_W-1:0] hit_addr;
    logic [ADDR_W-1:0] fill_addr;

    srm_xlate #(.SLOT_W(SLOT_W)) u_xl_hit (
        .in_grp   (req_grp),
        .in_slot  (req_slot),
        .in_off   (req_off),
        .res_grp  (lk_grp),
        .out_addr (hit_addr)
    );

    srm_xlate #(.SLOT_W(SLOT_W)) u_xl_fill (
        .in_grp   (pend_grp_q),
        .in_slot  (pend_slot_q),
        .in_off   (pend_off_q),
        .res_grp  (fill_grp),
        .out_addr (fill_addr)
    );

    // ---------------- sequencing ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            pend_grp_q   <= '0;
            pend_slot_q  <= '0;
            pend_off_q   <= '0;
            ovr_v_q      <= 1'b0;
            ovr_grp_q    <= '0;
            resp_valid_q <= 1'b0;
            resp_addr_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_fire) begin
                        if (lk_hit) begin
                            resp_valid_q <= 1'b1;
                            resp_addr_q  <= hit_addr;
                        end else begin
                            pend_grp_q  <= req_grp;
                            pend_slot_q <= req_slot;
                            pend_off_q  <= req_off;
                            ovr_v_q     <= 1'b0;
                            state_q     <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (fill_en) begin
                        resp_valid_q <= 1'b1;
                        resp_addr_q  <= fill_addr;
                        ovr_v_q      <= 1'b0;
                        state_q      <= ST_IDLE;
                    end else if (upd_hits_pend) begin
                        ovr_v_q   <= 1'b1;
                        ovr_grp_q <= upd_grp;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign resp_valid   = resp_valid_q;
    assign resp_addr    = resp_addr_q;
    assign tbl_rd_req   = (state_q == ST_WAIT);
    assign tbl_rd_slot  = pend_slot_q;
    assign tbl_wr_valid = upd_valid;
    assign tbl_wr_slot  = upd_slot;
    assign tbl_wr_grp   = upd_grp;

    // ---------------- assertions ----------------
    AST_HIT_ANSWERS_NEXT: assert property (@(posedge clk) disable iff (rst)
        (req_fire && lk_hit) |=> (resp_valid && !tbl_rd_req));         // R6

    AST_MISS_ISSUES_READ: assert property (@(posedge clk) disable iff (rst)
        (req_fire && !lk_hit) |=> (tbl_rd_req && !resp_valid));        // R7

    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        (tbl_rd_req && !tbl_rd_rvalid) |=> (tbl_rd_req && $stable(tbl_rd_slot))); // R7

    AST_FILL_ANSWERS: assert property (@(posedge clk) disable iff (rst)
        (tbl_rd_req && tbl_rd_rvalid) |=> (resp_valid && req_ready));  // R7

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        (req_fire && lk_hit) |=> (resp_addr[OFF_W-1:0] == $past(req_off))); // R2

endmodule

// File: tb/srm_remap_cache_tb.sv
module srm_remap_cache_tb;
    import srm_pkg::*;

    localparam int SLOT_W = 8;
    localparam int SET_W  = 4;
    localparam int NSLOT  = 1 << SLOT_W;
    localparam int ADDR_W = GRP_W + SLOT_W + OFF_W;
    localparam int LAT    = 3;
    localparam int NVEC   = 18;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              resp_valid;
    logic [ADDR_W-1:0] resp_addr;
    logic              tbl_rd_req;
    logic [SLOT_W-1:0] tbl_rd_slot;
    logic              tbl_rd_rvalid;
    grp_t              tbl_rd_data;
    logic              upd_valid = 1'b0;
    logic [SLOT_W-1:0] upd_slot = '0;
    grp_t              upd_grp = '0;
    logic              tbl_wr_valid;
    logic [SLOT_W-1:0] tbl_wr_slot;
    grp_t              tbl_wr_grp;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    srm_remap_cache #(.SLOT_W(SLOT_W), .SET_W(SET_W), .WAYS(4)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .resp_valid    (resp_valid),
        .resp_addr     (resp_addr),
        .tbl_rd_req    (tbl_rd_req),
        .tbl_rd_slot   (tbl_rd_slot),
        .tbl_rd_rvalid (tbl_rd_rvalid),
        .tbl_rd_data   (tbl_rd_data),
        .upd_valid     (upd_valid),
        .upd_slot      (upd_slot),
        .upd_grp       (upd_grp),
        .tbl_wr_valid  (tbl_wr_valid),
        .tbl_wr_slot   (tbl_wr_slot),
        .tbl_wr_grp    (tbl_wr_grp)
    );

    // ---------------- fast-memory table model ----------------
    grp_t tbl_mem [NSLOT];
    int   m_cnt;
    logic m_rvalid;
    grp_t m_data;
    int   nread;

    assign tbl_rd_rvalid = m_rvalid;
    assign tbl_rd_data   = m_data;

    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSLOT; s++) tbl_mem[s] <= grp_t'(s % 5);
            m_cnt    <= 0;
            m_rvalid <= 1'b0;
            m_data   <= '0;
            nread    <= 0;
        end else begin
            if (tbl_wr_valid) tbl_mem[tbl_wr_slot] <= tbl_wr_grp;
            if (m_rvalid) begin
                m_rvalid <= 1'b0;
            end else if (m_cnt != 0) begin
                m_cnt <= m_cnt - 1;
                if (m_cnt == 1) m_rvalid <= 1'b1;
            end else if (tbl_rd_req) begin
                m_cnt  <= LAT;
                m_data <= tbl_mem[tbl_rd_slot];   // sampled at issue
                nread  <= nread + 1;
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [ADDR_W-1:0] exp_addr(grp_t g, logic [SLOT_W-1:0] s, off_t o, grp_t r);
        if (g == r)      return {{GRP_W{1'b0}}, s, o};
        else if (g == 0) return {r, s, o};
        else             return {g, s, o};
    endfunction

    function automatic string rule_tag(grp_t g, grp_t r);
        if (g == r)      return "R3 fast resident";
        else if (g == 0) return "R4 displaced owner";
        else             return "R5 unchanged";
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input grp_t g, input logic [SLOT_W-1:0] s, input off_t o,
                          output logic [ADDR_W-1:0] got, output int lat, output int reads);
        int r0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {g, s, o};
        while (!req_ready) @(negedge clk);
        r0 = nread;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid) begin
            @(negedge clk);
            lat++;
        end
        got   = resp_addr;
        reads = nread - r0;
    endtask

    task automatic do_upd(input logic [SLOT_W-1:0] s, input grp_t g);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_slot  = s;
        upd_grp   = g;
        #1;
        chk(tbl_wr_valid && tbl_wr_slot == s && tbl_wr_grp == g, "R9 table write port",
            {tbl_wr_valid, tbl_wr_slot, tbl_wr_grp}, {1'b1, s, g});
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // ---------------- stimulus table ----------------
    typedef struct packed {
        logic [2:0]        g;
        logic [SLOT_W-1:0] s;
        logic [OFF_W-1:0]  o;
        logic              miss;
    } vec_t;

    // table starts with resident(slot) = slot % 5; slots 5,21,37,53,69 share set 5
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 8'd5,   11'h123, 1'b1},
        '{3'd2, 8'd5,   11'h7FF, 1'b0},
        '{3'd1, 8'd21,  11'h010, 1'b1},
        '{3'd0, 8'd21,  11'h020, 1'b0},
        '{3'd3, 8'd37,  11'h000, 1'b1},
        '{3'd2, 8'd37,  11'h004, 1'b0},
        '{3'd3, 8'd53,  11'h555, 1'b1},
        '{3'd4, 8'd5,   11'h001, 1'b0},
        '{3'd4, 8'd69,  11'h002, 1'b1},
        '{3'd0, 8'd5,   11'h003, 1'b0},
        '{3'd1, 8'd37,  11'h2AA, 1'b0},
        '{3'd1, 8'd21,  11'h3FF, 1'b1},
        '{3'd3, 8'd53,  11'h000, 1'b1},
        '{3'd0, 8'd69,  11'h100, 1'b1},
        '{3'd0, 8'd0,   11'h0AB, 1'b1},
        '{3'd2, 8'd255, 11'h7FF, 1'b1},
        '{3'd0, 8'd255, 11'h011, 1'b0},
        '{3'd7, 8'd255, 11'h666, 1'b0}
    };

    // ---------------- main sequence ----------------
    initial begin
        logic [ADDR_W-1:0] got;
        logic [ADDR_W-1:0] exp;
        int lat;
        int reads;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R1 resp_valid after reset", resp_valid, 0);
        chk(tbl_rd_req == 1'b0, "R1 tbl_rd_req after reset", tbl_rd_req, 0);

        for (int i = 0; i < NVEC; i++) begin
            exp = exp_addr(VECS[i].g, VECS[i].s, VECS[i].o, tbl_mem[VECS[i].s]);
            do_req(VECS[i].g, VECS[i].s, VECS[i].o, got, lat, reads);
            chk(got == exp, rule_tag(VECS[i].g, tbl_mem[VECS[i].s]), got, exp);
            chk(got[OFF_W-1:0] == VECS[i].o, "R2 offset kept", got[OFF_W-1:0], VECS[i].o);
            if (VECS[i].miss) begin
                chk(reads == 1 && lat > 1, "R7 R8 miss needs one table read", reads, 1);
            end else begin
                chk(reads == 0 && lat == 1, "R6 R8 R11 hit in one cycle", lat, 1);
            end
        end

        // R9: update of a cached slot (37 resident 2 -> 4)
        do_upd(8'd37, 3'd4);
        chk(tbl_mem[37] == 3'd4, "R9 table written", tbl_mem[37], 4);
        do_req(3'd4, 8'd37, 11'h050, got, lat, reads);
        chk(got == {3'd0, 8'd37, 11'h050}, "R9 cached copy updated", got, {3'd0, 8'd37, 11'h050});
        chk(lat == 1 && reads == 0, "R9 still a hit", lat, 1);

        // R9: update of an uncached slot (slot 5 was evicted)
        do_upd(8'd5, 3'd1);
        do_req(3'd1, 8'd5, 11'h070, got, lat, reads);
        chk(got == {3'd0, 8'd5, 11'h070}, "R9 refill sees update", got, {3'd0, 8'd5, 11'h070});
        chk(reads == 1, "R9 uncached slot misses", reads, 1);

        // R10: update during an outstanding miss on the same slot (100: 0 -> 2)
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {3'd2, 8'd100, 11'h123};
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        upd_valid = 1'b1;
        upd_slot  = 8'd100;
        upd_grp   = 3'd2;
        @(negedge clk);
        upd_valid = 1'b0;
        while (!resp_valid) @(negedge clk);
        chk(resp_addr == {3'd0, 8'd100, 11'h123}, "R10 in-flight override",
            resp_addr, {3'd0, 8'd100, 11'h123});
        do_req(3'd0, 8'd100, 11'h321, got, lat, reads);
        chk(got == {3'd2, 8'd100, 11'h321}, "R10 R4 installed override", got, {3'd2, 8'd100, 11'h321});
        chk(lat == 1, "R10 entry installed", lat, 1);

        // R1: reset in mid-run clears the cache
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(req_ready && !resp_valid && !tbl_rd_req, "R1 outputs after second reset",
            {req_ready, resp_valid, tbl_rd_req}, 3'b100);
        do_req(3'd0, 8'd37, 11'h0F0, got, lat, reads);
        chk(reads == 1, "R1 cache empty after reset", reads, 1);
        chk(got == {3'd2, 8'd37, 11'h0F0}, "R1 R4 translation after reset", got, {3'd2, 8'd37, 11'h0F0});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule